// File: doc/BRIEF.md
# LPC Memory Write Target

This block is the peripheral end of a Low Pin Count bus for memory writes. On every bus clock it samples the four-bit multiplexed address/data lines and the active-low frame signal. When the host opens a frame, the block checks the cycle-type nibble. If the cycle is a memory write, it collects a 32-bit address and an 8-bit data byte. It then takes the bus across the host turnaround, answers with a ready SYNC and hands the bus back.

On the local side, the captured address and byte appear on a memory-side port together with a single-clock write strobe. A flash controller or register file can consume them directly. An external tri-state buffer is controlled by the output-enable and output-value pins. Cycles of any other type are ignored. A frame that is cut short by the host, or by reset, leaves the bus released and no write issued.

Clock numbering below starts at 1 for the clock in which the START nibble is sampled. "After clock k" means the register outputs that follow the rising edge that samples clock k.

Top module: `lpc_mem_write_target`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `lad_oe`=0 and `wr_stb`=0.
- R2: A frame opens only when `lframe_n`=0 and `lad_in`=4'b0000 at the same edge. A 0000 nibble with `lframe_n` high, or any other nibble with `lframe_n` low, opens nothing.
- R3: The nibble in clock 2 is accepted only when bits [3:1] are 3'b011, and bit 0 is ignored. For any other value the block returns to idle: it never raises `lad_oe` or `wr_stb` for that frame.
- R4: Clocks 3 to 10 carry the address as nibbles, most significant first: clock 3 gives bits 31:28 and clock 10 gives bits 3:0.
- R5: Clocks 11 and 12 carry the data byte, low nibble first: clock 11 gives bits 3:0 and clock 12 gives bits 7:4.
- R6: After clock 13, `lad_oe`=1 with `lad_out`=4'b1111. Before that, `lad_oe` stays 0 throughout the frame.
- R7: After clock 14, `lad_oe`=1 with `lad_out`=4'b0000 (ready SYNC).
- R8: After clock 15, `lad_oe`=1 with `lad_out`=4'b1111. After clocks 16 and 17, `lad_oe`=0.
- R9: `wr_stb` is high for exactly one clock per accepted frame, after clock 14. In that clock `wr_addr` and `wr_data` hold the full address and byte of the frame.
- R10: If `lframe_n` is low at an edge inside an open frame, the frame is dropped. The next outputs are `lad_oe`=0 and `wr_stb`=0, and no strobe follows for it. If the nibble in that clock is 0000, a new frame starts in that clock.
- R11: Reset in the middle of a frame drops it and releases the bus after that edge.
- R12: A new frame whose START comes in the clock after clock 17 is decoded fully.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lframe_n | input | 1 | Active-low frame marker from the host |
| lad_in | input | 4 | Sampled value of the multiplexed bus lines |
| lad_out | output | 4 | Value the target drives onto the bus lines |
| lad_oe | output | 1 | Output enable for the bus line buffers |
| wr_stb | output | 1 | One-clock write request to the local memory side |
| wr_addr | output | 32 | Captured write address |
| wr_data | output | 8 | Captured write byte |

## Verification
The bench sweeps all 256 data values against varying addresses. A design that swapped the two data nibbles, or shifted the address in the wrong direction, would return a mismatched byte or address at the strobe. All sixteen cycle-type nibbles are also applied. A decoder that tested bit 0, or accepted a read or non-memory type, would drive the bus when it must stay silent.

Frames are cut off by `lframe_n` after every possible clock, and by reset during the SYNC clock. A design that held the bus, strobed late, or failed to restart on an abort carrying 0000 would show a stray enable or a lost next write. Back-to-back frames catch an off-by-one in the release sequence.

// File: rtl/lpcw_pkg.sv
`timescale 1ns/1ps
package lpcw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_DATA,
    ST_HTA0,
    ST_HTA1,
    ST_SYNC,
    ST_TTA0,
    ST_TTA1
  } lpcw_state_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_HIGH  = 4'b1111;
  localparam logic [2:0] TYPE_MEM_WR = 3'b011;
endpackage

// File: rtl/lpcw_seq.sv
`timescale 1ns/1ps
module lpcw_seq
  import lpcw_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int DATA_NIBS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lframe_n,
  input  logic [3:0]  lad_in,
  output lpcw_state_e state_nx,
  output logic        addr_en,
  output logic        data_en
);
  localparam int MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  lpcw_state_e      state_q;
  logic [CNT_W-1:0] beat_q, beat_nx;

  always_comb begin
    state_nx = state_q;
    beat_nx  = beat_q;
    if (!lframe_n) begin
      // frame marker low: open a new frame or drop the current one
      state_nx = (lad_in == NIB_START) ? ST_TYPE : ST_IDLE;
      beat_nx  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_nx = ST_IDLE;
        ST_TYPE: begin
          state_nx = (lad_in[3:1] == TYPE_MEM_WR) ? ST_ADDR : ST_IDLE;
          beat_nx  = '0;
        end
        ST_ADDR: begin
          if (beat_q == ADDR_LAST) begin
            state_nx = ST_DATA;
            beat_nx  = '0;
          end else begin
            beat_nx = beat_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (beat_q == DATA_LAST) begin
            state_nx = ST_HTA0;
            beat_nx  = '0;
          end else begin
            beat_nx = beat_q + 1'b1;
          end
        end
        ST_HTA0: state_nx = ST_HTA1;
        ST_HTA1: state_nx = ST_SYNC;
        ST_SYNC: state_nx = ST_TTA0;
        ST_TTA0: state_nx = ST_TTA1;
        ST_TTA1: state_nx = ST_IDLE;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_nx;
      beat_q  <= beat_nx;
    end
  end

  assign addr_en = lframe_n && (state_q == ST_ADDR);
  assign data_en = lframe_n && (state_q == ST_DATA);
endmodule

// File: rtl/lpcw_capture.sv
`timescale 1ns/1ps
module lpcw_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_en,
  input  logic              data_en,
  input  logic [3:0]        lad_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      // address: most significant nibble arrives first, shift toward the top
      if (addr_en) addr_q <= {addr_q[ADDR_W-5:0], lad_in};
      // data: least significant nibble arrives first, shift toward the bottom
      if (data_en) data_q <= {lad_in, data_q[DATA_W-1:4]};
    end
  end
endmodule

// File: rtl/lpcw_drive.sv
`timescale 1ns/1ps
module lpcw_drive
  import lpcw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lpcw_state_e state_nx,
  output logic        lad_oe,
  output logic [3:0]  lad_out,
  output logic        wr_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lad_oe  <= 1'b0;
      lad_out <= NIB_HIGH;
      wr_stb  <= 1'b0;
    end else begin
      lad_oe  <= (state_nx == ST_HTA1) || (state_nx == ST_SYNC) ||
                 (state_nx == ST_TTA0);
      lad_out <= (state_nx == ST_SYNC) ? NIB_READY : NIB_HIGH;
      wr_stb  <= (state_nx == ST_SYNC);
    end
  end
endmodule

// File: rtl/lpc_mem_write_target.sv
`timescale 1ns/1ps
module lpc_mem_write_target
  import lpcw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;

  lpcw_state_e state_nx;
  logic        addr_en;
  logic        data_en;

  lpcw_seq #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .lframe_n (lframe_n),
    .lad_in   (lad_in),
    .state_nx (state_nx),
    .addr_en  (addr_en),
    .data_en  (data_en)
  );

  lpcw_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_capture (
    .clk     (clk),
    .rst     (rst),
    .addr_en (addr_en),
    .data_en (data_en),
    .lad_in  (lad_in),
    .addr_q  (wr_addr),
    .data_q  (wr_data)
  );

  lpcw_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .state_nx (state_nx),
    .lad_oe   (lad_oe),
    .lad_out  (lad_out),
    .wr_stb   (wr_stb)
  );
endmodule

// File: rtl/lpcw_checker.sv
`timescale 1ns/1ps
module lpcw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lframe_n,
  input logic [3:0]        lad_out,
  input logic              lad_oe,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!lad_oe && !wr_stb)); // R1
  AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    lad_oe |-> (lad_out == 4'b0000 || lad_out == 4'b1111)); // R6
  AST_STB_WITH_SYNC: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (lad_oe && lad_out == 4'b0000)); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R9
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> ($stable(wr_addr) && $stable(wr_data))); // R9
  AST_HIGH_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && lframe_n) |=> (lad_oe && lad_out == 4'b1111)); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |=> (!lad_oe && !wr_stb)); // R10
endmodule

bind lpc_mem_write_target lpcw_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_lpcw_checker (
  .clk      (clk),
  .rst      (rst),
  .lframe_n (lframe_n),
  .lad_out  (lad_out),
  .lad_oe   (lad_oe),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/test_lpc_mem_write_target.sv
`timescale 1ns/1ps
module test_lpc_mem_write_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        wr_stb;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lpc_mem_write_target i_lpc_mem_write_target (
    .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic step(input logic f, input logic [3:0] l);
    lframe_n = f;
    lad_in   = l;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_bus(input string req, input logic oe, input logic [3:0] val,
                            input logic stb);
    checks++;
    if (lad_oe !== oe || (oe && lad_out !== val) || wr_stb !== stb) begin
      errors++;
      $display("FAIL %s: oe=%b out=%h stb=%b expected oe=%b out=%h stb=%b",
               req, lad_oe, lad_out, wr_stb, oe, val, stb);
    end
  endtask

  // drive the first n_clk clocks of a frame and check every clock
  task automatic frame(input logic [3:0] typ, input logic [31:0] a, input logic [7:0] d,
                       input int n_clk);
    logic acc;
    acc = (typ[3:1] == 3'b011);
    for (int k = 1; k <= n_clk; k++) begin
      logic       f;
      logic [3:0] l;
      f = 1'b1;
      l = 4'hF;
      if (k == 1) begin f = 1'b0; l = 4'h0; end
      else if (k == 2) l = typ;
      else if (k <= 10) l = a[(10-k)*4 +: 4];
      else if (k == 11) l = d[3:0];
      else if (k == 12) l = d[7:4];
      step(f, l);
      if (!acc) expect_bus("R3 ignored type", 1'b0, 4'hF, 1'b0);
      else if (k == 13) expect_bus("R6 turnaround", 1'b1, 4'hF, 1'b0);
      else if (k == 14) begin
        expect_bus("R7 R9 sync", 1'b1, 4'h0, 1'b1);
        checks++;
        if (wr_addr !== a) begin
          errors++;
          $display("FAIL R4 address: got %h expected %h", wr_addr, a);
        end
        checks++;
        if (wr_data !== d) begin
          errors++;
          $display("FAIL R5 data: got %h expected %h", wr_data, d);
        end
      end
      else if (k == 15) expect_bus("R8 drive high", 1'b1, 4'hF, 1'b0);
      else if (k >= 16) expect_bus("R8 release", 1'b0, 4'hF, 1'b0);
      else expect_bus("R6 quiet before turnaround", 1'b0, 4'hF, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    // R1: reset state
    repeat (3) step(1'b1, 4'hF);
    expect_bus("R1 reset", 1'b0, 4'hF, 1'b0);
    rst = 1'b0;
    step(1'b1, 4'hF);
    expect_bus("R1 after reset", 1'b0, 4'hF, 1'b0);

    // R4 R5: sweep every data byte with varied addresses and both write codes
    for (int d = 0; d < 256; d++) begin
      a = 32'h1234_5678 ^ (32'(d) * 32'h9E37_79B1);
      frame(d[0] ? 4'h7 : 4'h6, a, 8'(d), 17);
    end

    // R3: all cycle-type nibbles
    for (int t = 0; t < 16; t++) frame(4'(t), 32'hA5C3_0F96 + 32'(t), 8'(t * 17), 17);

    // R2: 0000 with frame marker high never opens a frame
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 4'h0);
      expect_bus("R2 no start with frame high", 1'b0, 4'hF, 1'b0);
    end
    // R2: frame marker low with a non-zero nibble, then a valid body
    step(1'b0, 4'h5);
    expect_bus("R2 bad start nibble", 1'b0, 4'hF, 1'b0);
    for (int k = 2; k <= 17; k++) begin
      step(1'b1, (k == 2) ? 4'h6 : 4'h0);
      expect_bus("R2 body after bad start", 1'b0, 4'hF, 1'b0);
    end

    // R10: abort after every clock with a non-start nibble
    for (int n = 1; n <= 16; n++) begin
      frame(4'h6, 32'hDEAD_BEEF - 32'(n), 8'(8'h3C + n), n);
      step(1'b0, 4'hA);
      expect_bus("R10 abort release", 1'b0, 4'hF, 1'b0);
      for (int k = 0; k < 17; k++) begin
        step(1'b1, 4'hF);
        expect_bus("R10 no late strobe", 1'b0, 4'hF, 1'b0);
      end
    end
    // R10: abort carrying 0000 restarts a frame at once
    for (int n = 2; n <= 16; n++) begin
      frame(4'h7, 32'h0BAD_F00D, 8'hE1, n);
      frame(4'h6, 32'h7654_3210 + 32'(n), 8'(n * 9), 17);
    end

    // R11: reset in the SYNC clock
    frame(4'h6, 32'hCAFE_0001, 8'h5A, 14);
    rst = 1'b1;
    step(1'b1, 4'hF);
    expect_bus("R11 reset mid frame", 1'b0, 4'hF, 1'b0);
    rst = 1'b0;
    step(1'b1, 4'hF);
    expect_bus("R11 quiet after reset", 1'b0, 4'hF, 1'b0);
    frame(4'h6, 32'hCAFE_0002, 8'hA5, 17);

    // R12: back-to-back frames
    for (int i = 0; i < 4; i++) frame(4'h7, 32'hF0E1_D2C3 ^ 32'(i), 8'(8'h81 ^ i), 17);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule